// File: doc/BRIEF.md
# Glitch-free system clock switcher

The block picks which of up to eight source clocks drives the system clock, and divides that clock by a programmable ratio. Software writes a requested source code and sets a start bit in a control register. The block then waits for the requested source to report ready. It turns off the old clock and then turns on the new one, each step through a synchronised handshake, so no runt pulse reaches the output. When it is done it updates the current-source field and clears the start bit. If the requested source never becomes ready, the attempt is dropped after a timeout. The only sign of the failure is that the current-source field keeps its old value.

A second register sets the post-divide ratio. It can also make a change of ratio move one step at a time rather than jump. Ratio changes that lower the ratio (frequency rising) and changes that raise it (frequency falling) each have their own stepping enable. A busy flag stays set until the programmed ratio is in effect.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the current and requested source codes are 0, the start bit is 0, the ratio field is 0 (divide by 1), both stepping enables are 0, busy is 0, and the system clock runs at the period of source 0.
- R2: Control register (address 0): bit 0 is the start bit, bits 10:8 hold the requested source code and read back as written, and bits 14:12 show the current source code and cannot be written.
- R3: A start with a ready requested source ends with the start bit cleared and the current field equal to the request. The system clock then has that source's period.
- R4: If the requested source's ready flag stays low for TIMEOUT (default 1024) reference cycles, the start bit clears and the current field and system clock stay unchanged. If ready rises before then, the switch completes.
- R5: While a switch is in progress, no high or low pulse on the system clock is shorter than the shorter half-period of the old and new sources, and at no time are two sources enabled at once.
- R6: While the start bit is set, writes to the control register are ignored: the requested field and the start bit do not change.
- R7: Slew register (address 1) bits 23:20 hold the ratio field. The system clock period is the source period times (field + 1).
- R8: Slew register bit 0 and div_busy_o are busy. Busy is set from the cycle after a ratio write until the effective ratio equals the target. With stepping off it is high for exactly one cycle.
- R9: Slew register bit 2 enables stepping when the ratio decreases, and bit 1 enables it when the ratio increases. Bits 10:8 give the step period minus one. When stepping, the ratio moves by one every (period field + 1) reference cycles, so busy lasts |delta| x (field + 1) cycles.
- R10: A start whose requested code equals the current code clears the start bit on the next cycle and leaves the current field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock for registers and sequencing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | NSRC | Source clocks |
| src_rdy_i | input | NSRC | Per-source ready flags (asynchronous) |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 slew |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| sys_clk_o | output | 1 | Divided, selected system clock |
| cur_src_o | output | 3 | Current source code |
| div_busy_o | output | 1 | Ratio change in progress |

## Verification
Switches are tried to a source that is ready, to the source already in use, to a source that never becomes ready, and to a source whose ready flag rises partway through the wait. This separates a completed handover from a silent abort and from the shortcut taken when nothing needs to change. A pulse-width monitor on the system clock during handovers shows whether a runt pulse escaped. Ratio changes are tried as a plain jump, as a stepped increase, and as a decrease with only the other direction's stepping enabled. Busy duration and the measured output period then show whether each direction's enable and the step period are honoured.

// File: rtl/sysclk_switch_pkg.sv
`timescale 1ns/1ps
package sysclk_switch_pkg;
  localparam int SRC_W  = 3;
  localparam int DIV_W  = 4;
  localparam int STEP_W = 3;

  localparam int CTRL_SWEN_BIT = 0;
  localparam int CTRL_REQ_LSB  = 8;
  localparam int CTRL_CUR_LSB  = 12;

  localparam int SLEW_BUSY_BIT = 0;
  localparam int SLEW_DN_BIT   = 1;
  localparam int SLEW_UP_BIT   = 2;
  localparam int SLEW_STEP_LSB = 8;
  localparam int SLEW_DIV_LSB  = 20;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_OFF, SQ_ON} sq_state_e;
endpackage

// File: rtl/sysclk_switch_seq.sv
`timescale 1ns/1ps
module sysclk_switch_seq
  import sysclk_switch_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int TMO  = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] req_wr_i,
  input  logic             swen_wr_i,
  input  logic [NSRC-1:0]  rdy_i,
  input  logic [NSRC-1:0]  fb_i,
  output logic [NSRC-1:0]  sel_o,
  output logic [SRC_W-1:0] cur_o,
  output logic [SRC_W-1:0] req_o,
  output logic             swen_o
);
  localparam int TW   = $clog2(TMO + 1);
  localparam int NPAD = 1 << SRC_W;

  logic [NSRC-1:0] rdy_m, rdy_s, fb_m, fb_s;
  logic [NPAD-1:0] rdy_pad, fb_pad;
  logic [NSRC-1:0] req_hot;
  sq_state_e       st_q;
  logic [TW-1:0]   tmo_q;
  logic [SRC_W-1:0] cur_q, req_q;
  logic            swen_q;
  logic [NSRC-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_m <= '0; rdy_s <= '0; fb_m <= '0; fb_s <= '0;
    end else begin
      rdy_m <= rdy_i; rdy_s <= rdy_m;
      fb_m  <= fb_i;  fb_s  <= fb_m;
    end
  end

  always_comb begin
    rdy_pad = '0; rdy_pad[NSRC-1:0] = rdy_s;
    fb_pad  = '0; fb_pad[NSRC-1:0]  = fb_s;
    for (int i = 0; i < NSRC; i++) req_hot[i] = (SRC_W'(i) == req_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE; tmo_q <= '0; cur_q <= '0; req_q <= '0;
      swen_q <= 1'b0; sel_q <= NSRC'(1);
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (swen_q) begin
            if (req_q == cur_q) swen_q <= 1'b0;
            else begin st_q <= SQ_WAIT; tmo_q <= '0; end
          end else if (wr_i) begin
            req_q  <= req_wr_i;
            swen_q <= swen_wr_i;
          end
        end
        SQ_WAIT: begin
          if (rdy_pad[req_q]) begin
            sel_q <= '0; st_q <= SQ_OFF;
          end else if (tmo_q == TW'(TMO - 1)) begin
            swen_q <= 1'b0; st_q <= SQ_IDLE;
          end else tmo_q <= tmo_q + 1'b1;
        end
        // old clock must be seen off before the new one is armed
        SQ_OFF: if (fb_pad == '0) begin sel_q <= req_hot; st_q <= SQ_ON; end
        SQ_ON: if (fb_pad[req_q]) begin
          cur_q <= req_q; swen_q <= 1'b0; st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign sel_o  = sel_q;
  assign cur_o  = cur_q;
  assign req_o  = req_q;
  assign swen_o = swen_q;
endmodule

// File: rtl/sysclk_switch_gmux.sv
`timescale 1ns/1ps
module sysclk_switch_gmux #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] src_clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] sel_i,
  output logic [NSRC-1:0] en_o,
  output logic            clk_o
);
  logic [NSRC-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic RV = (g == 0);
    logic s1_q, s2_q, en_q;
    always_ff @(posedge src_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) begin s1_q <= RV; s2_q <= RV; end
      else begin s1_q <= sel_i[g]; s2_q <= s1_q; end
    end
    // enable changes only while the source is low
    always_ff @(negedge src_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= RV;
      else en_q <= s2_q;
    end
    assign gated[g] = src_clk_i[g] & en_q;
    assign en_o[g]  = en_q;
  end

  assign clk_o = |gated;
endmodule

// File: rtl/sysclk_switch_slew.sv
`timescale 1ns/1ps
module sysclk_switch_slew
  import sysclk_switch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              dn_wr_i,
  input  logic              up_wr_i,
  input  logic [STEP_W-1:0] step_wr_i,
  input  logic [DIV_W-1:0]  tgt_wr_i,
  output logic [DIV_W-1:0]  eff_o,
  output logic              busy_o,
  output logic [31:0]       rd_o
);
  logic              dn_q, up_q;
  logic [STEP_W-1:0] step_q, cnt_q;
  logic [DIV_W-1:0]  tgt_q, eff_q;
  logic              lower, stepping;

  assign lower    = tgt_q < eff_q;
  assign stepping = lower ? up_q : dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_q <= 1'b0; up_q <= 1'b0; step_q <= '0; tgt_q <= '0;
    end else if (wr_i) begin
      dn_q <= dn_wr_i; up_q <= up_wr_i; step_q <= step_wr_i; tgt_q <= tgt_wr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= '0; cnt_q <= '0;
    end else if (eff_q == tgt_q) begin
      cnt_q <= '0;
    end else if (!stepping) begin
      eff_q <= tgt_q; cnt_q <= '0;
    end else if (cnt_q == step_q) begin
      eff_q <= lower ? eff_q - 1'b1 : eff_q + 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = eff_q != tgt_q;
  assign eff_o  = eff_q;

  always_comb begin
    rd_o = '0;
    rd_o[SLEW_BUSY_BIT] = busy_o;
    rd_o[SLEW_DN_BIT]   = dn_q;
    rd_o[SLEW_UP_BIT]   = up_q;
    rd_o[SLEW_STEP_LSB +: STEP_W] = step_q;
    rd_o[SLEW_DIV_LSB +: DIV_W]   = tgt_q;
  end
endmodule

// File: rtl/sysclk_switch_postdiv.sv
`timescale 1ns/1ps
module sysclk_switch_postdiv
  import sysclk_switch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] r_m, r_s, cnt_q, cnt_nxt;
  logic             div_q, hi;

  assign cnt_nxt = (cnt_q >= r_s) ? '0 : cnt_q + 1'b1;
  assign hi      = {1'b0, cnt_nxt, 1'b0} < ({2'b00, r_s} + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_m <= '0; r_s <= '0; cnt_q <= '0; div_q <= 1'b0;
    end else begin
      r_m <= ratio_i; r_s <= r_m;
      cnt_q <= cnt_nxt; div_q <= hi;
    end
  end

  assign clk_o = (r_s == '0) ? clk_i : div_q;
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sysclk_switch_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int TIMEOUT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_clk_i,
  input  logic [NSRC-1:0]   src_rdy_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_clk_o,
  output logic [SRC_W-1:0]  cur_src_o,
  output logic              div_busy_o
);
  logic [NSRC-1:0]  sel, en_fb;
  logic [SRC_W-1:0] cur_src, req_src;
  logic             swen, mux_clk;
  logic [DIV_W-1:0] eff;
  logic [31:0]      slew_rd, ctrl_rd;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[31:24], wdata_i[19:11], wdata_i[7:3]};

  sysclk_switch_seq #(.NSRC(NSRC), .TMO(TIMEOUT)) u_seq (
    .clk_i, .rst_ni,
    .wr_i      (wr_i & ~addr_i),
    .req_wr_i  (wdata_i[CTRL_REQ_LSB +: SRC_W]),
    .swen_wr_i (wdata_i[CTRL_SWEN_BIT]),
    .rdy_i     (src_rdy_i),
    .fb_i      (en_fb),
    .sel_o     (sel),
    .cur_o     (cur_src),
    .req_o     (req_src),
    .swen_o    (swen)
  );

  sysclk_switch_gmux #(.NSRC(NSRC)) u_gmux (
    .src_clk_i, .rst_ni,
    .sel_i (sel),
    .en_o  (en_fb),
    .clk_o (mux_clk)
  );

  sysclk_switch_slew u_slew (
    .clk_i, .rst_ni,
    .wr_i      (wr_i & addr_i),
    .dn_wr_i   (wdata_i[SLEW_DN_BIT]),
    .up_wr_i   (wdata_i[SLEW_UP_BIT]),
    .step_wr_i (wdata_i[SLEW_STEP_LSB +: STEP_W]),
    .tgt_wr_i  (wdata_i[SLEW_DIV_LSB +: DIV_W]),
    .eff_o     (eff),
    .busy_o    (div_busy_o),
    .rd_o      (slew_rd)
  );

  sysclk_switch_postdiv u_pdiv (
    .clk_i   (mux_clk),
    .rst_ni,
    .ratio_i (eff),
    .clk_o   (sys_clk_o)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_SWEN_BIT] = swen;
    ctrl_rd[CTRL_REQ_LSB +: SRC_W] = req_src;
    ctrl_rd[CTRL_CUR_LSB +: SRC_W] = cur_src;
  end

  assign rdata_o   = addr_i ? slew_rd : ctrl_rd;
  assign cur_src_o = cur_src;
endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk #(
  parameter int NSRC = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            swen_i,
  input logic [2:0]      cur_i,
  input logic [2:0]      req_i,
  input logic [NSRC-1:0] sel_i,
  input logic [NSRC-1:0] fb_i,
  input logic [3:0]      eff_i,
  input logic [31:0]     slew_rd_i,
  input logic            wr_i,
  input logic            addr_i
);
  // R6
  ctrl_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swen_i && wr_i && !addr_i) |=> ($stable(req_i) && swen_i));

  // R3
  cur_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_i) |-> ($fell(swen_i) && cur_i == req_i));

  // R5
  one_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fb_i));

  // R5
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  // R9
  slew_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_rd_i[1] && slew_rd_i[2]) |=>
      (eff_i == $past(eff_i) || eff_i == $past(eff_i) + 4'd1 || eff_i == $past(eff_i) - 4'd1));

  // R8
  eff_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(eff_i) |-> $past(slew_rd_i[0]));
endmodule

bind sysclk_switch sysclk_switch_chk #(.NSRC(NSRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .swen_i    (swen),
  .cur_i     (cur_src),
  .req_i     (req_src),
  .sel_i     (sel),
  .fb_i      (en_fb),
  .eff_i     (eff),
  .slew_rd_i (slew_rd),
  .wr_i      (wr_i),
  .addr_i    (addr_i)
);

// File: tb/sysclk_switch_tb.sv
`timescale 1ns/1ps
module sysclk_switch_tb;
  localparam int NSRC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sc [NSRC];
  logic [NSRC-1:0] src_clk, src_rdy;
  logic wr = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic sys_clk, busy;
  logic [2:0] cur;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    initial sc[g] = 1'b0;
    always #(3 + g) sc[g] = ~sc[g];
  end
  always_comb for (int i = 0; i < NSRC; i++) src_clk[i] = sc[i];

  sysclk_switch #(.NSRC(NSRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk), .src_rdy_i(src_rdy),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sys_clk_o(sys_clk), .cur_src_o(cur), .div_busy_o(busy));

  function automatic real src_per(int s); return 2.0 * (3 + s); endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural ratio model: target, effective, wait counter
  int m_tgt, m_eff, m_wait, m_step; bit m_up, m_dn;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tgt = 0; m_eff = 0; m_wait = 0; m_step = 0; m_up = 0; m_dn = 0;
    end else begin
      if (m_eff == m_tgt) m_wait = 0;
      else if (!((m_tgt < m_eff) ? m_up : m_dn)) begin m_eff = m_tgt; m_wait = 0; end
      else if (m_wait == m_step) begin m_eff += (m_tgt < m_eff) ? -1 : 1; m_wait = 0; end
      else m_wait++;
      if (wr && addr) begin
        m_dn = wdata[1]; m_up = wdata[2];
        m_step = int'(wdata[10:8]); m_tgt = int'(wdata[23:20]);
      end
    end
  end
  // R8 per-cycle comparison of busy against the model
  always @(negedge clk) if (rst_n)
    chk(busy == (m_eff != m_tgt), "R8", "busy vs model", longint'(busy), longint'(m_eff != m_tgt));

  // pulse-width monitor
  bit mon_en = 0; int runts = 0; real last_t = 0.0, min_w = 0.0;
  always @(sys_clk) begin
    if (mon_en && ($realtime - last_t) < min_w) runts++;
    last_t = $realtime;
  end

  task automatic wreg(input logic a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 1'b0;
  endtask

  task automatic rreg(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 1'b0;
  endtask

  task automatic wait_done(input int maxc, output int cyc);
    logic [31:0] d;
    cyc = 0;
    do begin rreg(1'b0, d); cyc++; end while (d[0] && cyc < maxc);
  endtask

  task automatic period(input real exp, input string req);
    realtime t0, t1;
    repeat (20) @(negedge clk);
    @(posedge sys_clk); @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); t1 = $realtime;
    chk((t1 - t0) > exp - 0.5 && (t1 - t0) < exp + 0.5, req, "sys clock period ns",
        longint'(t1 - t0), longint'(exp));
  endtask

  task automatic sw(input int s, input string req);
    logic [31:0] d; int c;
    min_w = ((src_per(s) < src_per(int'(cur))) ? src_per(s) : src_per(int'(cur))) / 2.0 - 0.1;
    runts = 0; mon_en = 1;
    wreg(1'b0, (s << 8) | 1);
    wait_done(400, c);
    repeat (10) @(negedge clk);
    mon_en = 0;
    rreg(1'b0, d);
    chk(d[0] == 1'b0, req, "start bit cleared", longint'(d[0]), 0);
    chk(int'(d[14:12]) == s, req, "current source", longint'(d[14:12]), s);
    chk(runts == 0, "R5", "runt pulses during switch", runts, 0);
  endtask

  initial begin
    logic [31:0] d; int c;
    src_rdy = '1;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rreg(1'b0, d); chk(d == 32'h0, "R1", "control after reset", d, 0);
    rreg(1'b1, d); chk(d == 32'h0, "R1", "slew after reset", d, 0);
    chk(cur == 3'd0, "R1", "cur_src_o", cur, 0);
    period(src_per(0), "R1");
    // R2 layout, current field read-only
    wreg(1'b0, 32'h0000_7200);
    rreg(1'b0, d); chk(d == 32'h0000_0200, "R2", "request readback, cur read-only", d, 32'h200);
    // R3 normal switch
    sw(2, "R3"); period(src_per(2), "R3");
    // R10 same source
    wreg(1'b0, (2 << 8) | 1);
    rreg(1'b0, d); chk(d[0] == 1'b0 && d[14:12] == 3'd2, "R10", "same-source start", d, 32'h2200);
    // R4 timeout, R6 writes locked
    src_rdy[5] = 1'b0;
    wreg(1'b0, (5 << 8) | 1);
    repeat (100) @(negedge clk);
    wreg(1'b0, (1 << 8));
    rreg(1'b0, d); chk(d[10:8] == 3'd5 && d[0], "R6", "write ignored while switching", d[10:8], 5);
    repeat (900) @(negedge clk);
    rreg(1'b0, d); chk(d[0] == 1'b1, "R4", "still waiting before timeout", d[0], 1);
    repeat (40) @(negedge clk);
    rreg(1'b0, d); chk(d[0] == 1'b0 && d[14:12] == 3'd2, "R4", "aborted, current kept", d[14:12], 2);
    period(src_per(2), "R4");
    // R4 late ready
    src_rdy[4] = 1'b0;
    wreg(1'b0, (4 << 8) | 1);
    repeat (200) @(negedge clk);
    src_rdy[4] = 1'b1;
    wait_done(400, c);
    rreg(1'b0, d); chk(d[14:12] == 3'd4, "R4", "late-ready switch", d[14:12], 4);
    period(src_per(4), "R4");
    // R7 / R8 jump
    wreg(1'b1, 32'h0020_0000);
    c = 0; while (busy) begin c++; @(negedge clk); end
    chk(c == 1, "R8", "jump busy cycles", c, 1);
    rreg(1'b1, d); chk(d == 32'h0020_0000, "R7", "slew readback", d, 32'h0020_0000);
    period(src_per(4) * 3, "R7");
    // R9 stepped increase, both enables, period 2
    wreg(1'b1, 32'h0050_0106);
    c = 0; while (busy) begin c++; @(negedge clk); end
    chk(c == 6, "R9", "stepped busy cycles", c, 6);
    period(src_per(4) * 6, "R9");
    // R9 decrease with only increase-stepping enabled: jump
    wreg(1'b1, 32'h0000_0302);
    c = 0; while (busy) begin c++; @(negedge clk); end
    chk(c == 1, "R9", "decrease without up-stepping", c, 1);
    period(src_per(4), "R9");
    // R3 back to source 0
    sw(0, "R3"); period(src_per(0), "R3");
    chk(cur == 3'd0, "R3", "cur_src_o after return", cur, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule